// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer for a Bus State Analyzer

This block decides, cycle by cycle, when a bus state analyzer triggers and which samples it keeps. Eleven pattern terms compare the sampled bus signals, error signals and decoded bus-state signals against programmed values. Each bit of a value can be made a don't-care by a per-bit care mask. A sequencer of up to sixteen levels combines the terms and walks from level to level. A shared preloadable down-counter lets a level wait for a number of qualifying cycles before it moves on.

Each level chooses a subset of the terms. It joins them with AND or OR, and it can invert the result. The level names the next level, says whether advancing from it fires the trigger, and picks its own storage rule. The storage rule is what lets the trace memory skip idle or wait cycles. After the trigger, a post-trigger count of stored samples decides where the trigger sits in the trace memory. When that count runs out, the block raises a done flag and stops storing. The trace RAM, the bus-state decoder and the register interface are outside the block: all configuration arrives on static input ports. A new acquisition starts with reset.

Top module: `trig_seq`

## Requirements
- R1: While reset is held, and on the first sample point after it is released, `level_o` is 0 and `trig_o`, `store_o` and `done_o` are all low.
- R2: A pattern term matches when, at every bit whose care bit is 1, the observed bit equals the value bit. Bits whose care bit is 0 are ignored. Terms 0 to 3 observe the vector {`ext_trig_i`, `bus_i`}, with the trigger lines in the upper bits. Term 4 observes `err_i`. Terms 5 to 10 observe `bstate_i`. In the level select mask, bit i stands for term i.
- R3: In AND mode (`lvl_or_i` bit = 0), a level's condition is true when every selected term matches. With no term selected, the condition is true.
- R4: In OR mode (`lvl_or_i` bit = 1), a level's condition is true when any selected term matches. With no term selected, the condition is false. When a level's invert bit is 1, the condition is complemented after the AND or OR.
- R5: When the current level's condition is true and the level does not wait on the counter, `level_o` takes that level's next-level index at the following clock. When the condition is false, the level is kept.
- R6: The counter loads `cnt_preload_i` at reset and again on every level advance. It decrements only on cycles when a waiting level's condition is true. A waiting level with preload P therefore advances on its (P+1)-th cycle with a true condition, and cycles with a false condition do not count.
- R7: An advance out of a level whose trigger bit is set makes `trig_o` high for exactly one cycle, one clock after the deciding cycle. This happens only the first time in an acquisition.
- R8: `store_o` gives, one clock late, the storage decision for each sampled cycle, using the current level's 2-bit select: 0 never stores, 1 always stores, 2 stores when the condition is true, 3 stores when it is false. The cycle that fires the trigger uses the select of the level it leaves.
- R9: After the trigger, exactly `post_count_i` further samples are stored. On the next cycle `done_o` rises. It then stays high until reset, and `store_o` stays low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts an acquisition |
| bus_i | input | BUS_W | Sampled bus signals |
| ext_trig_i | input | EXT_W (4) | External trigger lines used as inputs |
| err_i | input | ERR_W | Protocol and data error flags |
| bstate_i | input | ST_W | Decoded bus-state signals |
| bus_val_i | input | 4 x (BUS_W+EXT_W) | Value for each of the bus terms |
| bus_care_i | input | 4 x (BUS_W+EXT_W) | Care mask for each of the bus terms |
| err_val_i | input | ERR_W | Value for the error term |
| err_care_i | input | ERR_W | Care mask for the error term |
| st_val_i | input | 6 x ST_W | Value for each of the bus-state terms |
| st_care_i | input | 6 x ST_W | Care mask for each of the bus-state terms |
| lvl_sel_i | input | LEVELS x 11 | Term select mask for each level |
| lvl_or_i | input | LEVELS | Per level: 1 selects OR, 0 selects AND |
| lvl_inv_i | input | LEVELS | Per level: invert the combined condition |
| lvl_next_i | input | LEVELS x LVL_W | Per level: index of the next level |
| lvl_trig_i | input | LEVELS | Per level: advancing out of it fires the trigger |
| lvl_wait_i | input | LEVELS | Per level: advancing also needs the counter at zero |
| lvl_store_i | input | LEVELS x 2 | Per level: storage select |
| cnt_preload_i | input | CNT_W | Preload value for the counter |
| post_count_i | input | POST_W | Number of samples to store after the trigger |
| level_o | output | LVL_W | Current sequencer level |
| trig_o | output | 1 | One-cycle trigger pulse |
| store_o | output | 1 | Store qualifier for the previous cycle's sample |
| done_o | output | 1 | Acquisition complete |

## Verification
Each of the eleven terms is swept in turn, with a single-term select, over vectors built arithmetically from the term's value and care mask. An exact-match vector shows that a match is found. A vector with only the don't-care bits flipped shows that those bits are ignored. Further mixed vectors check the per-bit compare on the error and bus-state groups as well as the bus group. Two terms on separate bus bits are then driven through all four match combinations, in both AND and OR mode, with and without inversion, and with the select mask both full and empty. This separates the two combine modes and their empty-mask results. A three-level program is run for several counter preloads and post-trigger counts. Its second level sees alternating true and false cycles, which separates counting only true cycles from counting every cycle. It also exposes a missing counter reload, an early or repeated trigger, and an off-by-one in the post-trigger count.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
    localparam int N_BUS_TERMS = 4;
    localparam int N_ERR_TERMS = 1;
    localparam int N_ST_TERMS  = 6;
    localparam int N_TERMS     = N_BUS_TERMS + N_ERR_TERMS + N_ST_TERMS;
    localparam int EXT_W       = 4;
    localparam int ERR_TERM_IX = N_BUS_TERMS;
    localparam int ST_TERM_IX  = N_BUS_TERMS + N_ERR_TERMS;

    typedef enum logic [1:0] {
        STO_NEVER    = 2'd0,
        STO_ALWAYS   = 2'd1,
        STO_ON_COND  = 2'd2,
        STO_OFF_COND = 2'd3
    } store_mode_e;
endpackage

// File: rtl/pat_term.sv
module pat_term #(
    parameter int W = 8
) (
    input  logic [W-1:0] sample_i,
    input  logic [W-1:0] value_i,
    input  logic [W-1:0] care_i,
    output logic         hit_o
);
    always_comb begin
        hit_o = ~|((sample_i ^ value_i) & care_i);
    end
endmodule

// File: rtl/term_bank.sv
module term_bank
    import trig_seq_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int ERR_W = 8,
    parameter int ST_W  = 8,
    localparam int BT_W = BUS_W + EXT_W
) (
    input  logic [BT_W-1:0]                   bus_vec_i,
    input  logic [ERR_W-1:0]                  err_i,
    input  logic [ST_W-1:0]                   bstate_i,
    input  logic [N_BUS_TERMS-1:0][BT_W-1:0]  bus_val_i,
    input  logic [N_BUS_TERMS-1:0][BT_W-1:0]  bus_care_i,
    input  logic [ERR_W-1:0]                  err_val_i,
    input  logic [ERR_W-1:0]                  err_care_i,
    input  logic [N_ST_TERMS-1:0][ST_W-1:0]   st_val_i,
    input  logic [N_ST_TERMS-1:0][ST_W-1:0]   st_care_i,
    output logic [N_TERMS-1:0]                hits_o
);
    for (genvar b = 0; b < N_BUS_TERMS; b++) begin : g_bus
        pat_term #(.W(BT_W)) u_term (
            .sample_i(bus_vec_i),
            .value_i (bus_val_i[b]),
            .care_i  (bus_care_i[b]),
            .hit_o   (hits_o[b])
        );
    end

    pat_term #(.W(ERR_W)) u_err_term (
        .sample_i(err_i),
        .value_i (err_val_i),
        .care_i  (err_care_i),
        .hit_o   (hits_o[ERR_TERM_IX])
    );

    for (genvar s = 0; s < N_ST_TERMS; s++) begin : g_st
        pat_term #(.W(ST_W)) u_term (
            .sample_i(bstate_i),
            .value_i (st_val_i[s]),
            .care_i  (st_care_i[s]),
            .hit_o   (hits_o[ST_TERM_IX + s])
        );
    end
endmodule

// File: rtl/lvl_cond.sv
module lvl_cond
    import trig_seq_pkg::*;
(
    input  logic [N_TERMS-1:0] hits_i,
    input  logic [N_TERMS-1:0] sel_i,
    input  logic               or_mode_i,
    input  logic               inv_i,
    output logic               cond_o
);
    logic all_sel;
    logic any_sel;

    always_comb begin
        all_sel = &(hits_i | ~sel_i);
        any_sel = |(hits_i & sel_i);
        cond_o  = (or_mode_i ? any_sel : all_sel) ^ inv_i;
    end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int ERR_W  = 8,
    parameter int ST_W   = 8,
    parameter int LEVELS = 16,
    parameter int CNT_W  = 16,
    parameter int POST_W = 12,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int BT_W  = BUS_W + EXT_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [BUS_W-1:0]                  bus_i,
    input  logic [EXT_W-1:0]                  ext_trig_i,
    input  logic [ERR_W-1:0]                  err_i,
    input  logic [ST_W-1:0]                   bstate_i,
    input  logic [N_BUS_TERMS-1:0][BT_W-1:0]  bus_val_i,
    input  logic [N_BUS_TERMS-1:0][BT_W-1:0]  bus_care_i,
    input  logic [ERR_W-1:0]                  err_val_i,
    input  logic [ERR_W-1:0]                  err_care_i,
    input  logic [N_ST_TERMS-1:0][ST_W-1:0]   st_val_i,
    input  logic [N_ST_TERMS-1:0][ST_W-1:0]   st_care_i,
    input  logic [LEVELS-1:0][N_TERMS-1:0]    lvl_sel_i,
    input  logic [LEVELS-1:0]                 lvl_or_i,
    input  logic [LEVELS-1:0]                 lvl_inv_i,
    input  logic [LEVELS-1:0][LVL_W-1:0]      lvl_next_i,
    input  logic [LEVELS-1:0]                 lvl_trig_i,
    input  logic [LEVELS-1:0]                 lvl_wait_i,
    input  logic [LEVELS-1:0][1:0]            lvl_store_i,
    input  logic [CNT_W-1:0]                  cnt_preload_i,
    input  logic [POST_W-1:0]                 post_count_i,
    output logic [LVL_W-1:0]                  level_o,
    output logic                              trig_o,
    output logic                              store_o,
    output logic                              done_o
);
    typedef struct packed {
        logic [LVL_W-1:0]  level;
        logic [CNT_W-1:0]  cnt;
        logic              cnt_ld;
        logic [POST_W-1:0] post;
        logic              triggered;
        logic              done;
        logic              trig;
        logic              store;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [N_TERMS-1:0] hits;
    logic               cond;
    logic [N_TERMS-1:0] cur_sel;
    logic               cur_or, cur_inv, cur_trig, cur_wait;
    logic [LVL_W-1:0]   cur_next;
    store_mode_e        cur_store;
    logic [CNT_W-1:0]   cnt_cur;
    logic               cnt_zero;
    logic               advance;
    logic               want_store;

    term_bank #(.BUS_W(BUS_W), .ERR_W(ERR_W), .ST_W(ST_W)) u_terms (
        .bus_vec_i (BT_W'({ext_trig_i, bus_i})),
        .err_i     (err_i),
        .bstate_i  (bstate_i),
        .bus_val_i (bus_val_i),
        .bus_care_i(bus_care_i),
        .err_val_i (err_val_i),
        .err_care_i(err_care_i),
        .st_val_i  (st_val_i),
        .st_care_i (st_care_i),
        .hits_o    (hits)
    );

    always_comb begin
        cur_sel   = lvl_sel_i[s_q.level];
        cur_or    = lvl_or_i[s_q.level];
        cur_inv   = lvl_inv_i[s_q.level];
        cur_next  = lvl_next_i[s_q.level];
        cur_trig  = lvl_trig_i[s_q.level];
        cur_wait  = lvl_wait_i[s_q.level];
        cur_store = store_mode_e'(lvl_store_i[s_q.level]);
    end

    lvl_cond u_cond (
        .hits_i   (hits),
        .sel_i    (cur_sel),
        .or_mode_i(cur_or),
        .inv_i    (cur_inv),
        .cond_o   (cond)
    );

    always_comb begin
        s_d        = s_q;
        s_d.trig   = 1'b0;
        s_d.store  = 1'b0;

        cnt_cur    = s_q.cnt_ld ? cnt_preload_i : s_q.cnt;
        cnt_zero   = (cnt_cur == '0);
        advance    = cond && (!cur_wait || cnt_zero);

        unique case (cur_store)
            STO_NEVER:    want_store = 1'b0;
            STO_ALWAYS:   want_store = 1'b1;
            STO_ON_COND:  want_store = cond;
            STO_OFF_COND: want_store = !cond;
            default:      want_store = 1'b0;
        endcase

        if (!s_q.done) begin
            if (cond && cur_wait && !cnt_zero) begin
                s_d.cnt    = cnt_cur - 1'b1;
                s_d.cnt_ld = 1'b0;
            end
            if (advance) begin
                s_d.level  = cur_next;
                s_d.cnt_ld = 1'b1;
            end

            if (s_q.triggered) begin
                if (s_q.post == '0) begin
                    s_d.done = 1'b1;
                end else if (want_store) begin
                    s_d.store = 1'b1;
                    s_d.post  = s_q.post - 1'b1;
                end
            end else begin
                s_d.store = want_store;
                if (advance && cur_trig) begin
                    s_d.triggered = 1'b1;
                    s_d.trig      = 1'b1;
                    s_d.post      = post_count_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{level: '0, cnt: '0, cnt_ld: 1'b1, post: '0,
                     triggered: 1'b0, done: 1'b0, trig: 1'b0, store: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.level;
    assign trig_o  = s_q.trig;
    assign store_o = s_q.store;
    assign done_o  = s_q.done;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
    parameter int POST_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_o,
    input logic              store_o,
    input logic              done_o,
    input logic [POST_W-1:0] post_count_i
);
    logic              seen_trig;
    logic [POST_W:0]   post_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_trig <= 1'b0;
            post_seen <= '0;
        end else begin
            if (trig_o) seen_trig <= 1'b1;
            if (store_o && seen_trig) post_seen <= post_seen + 1'b1;
        end
    end

    // R7: a second trigger pulse in one acquisition is illegal
    a_r7_single_trig: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !seen_trig);

    // R7: the pulse lasts a single cycle
    a_r7_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R9: completion only follows a trigger
    a_r9_done_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> seen_trig);

    // R9: exact number of post-trigger stores before completion
    a_r9_post_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (post_seen == {1'b0, post_count_i}));

    // R9: nothing stored once complete
    a_r9_no_store_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !store_o);

    // R9: completion is held until reset
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);
endmodule

bind trig_seq trig_seq_chk #(.POST_W(POST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_o      (trig_o),
    .store_o     (store_o),
    .done_o      (done_o),
    .post_count_i(post_count_i)
);

// File: tb/sim_trig_seq.sv
`timescale 1ns/1ps
module sim_trig_seq;
    import trig_seq_pkg::*;

    localparam int BUS_W = 16, ERR_W = 8, ST_W = 8, LEVELS = 16;
    localparam int CNT_W = 16, POST_W = 12, LVL_W = 4, BT_W = BUS_W + EXT_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BUS_W-1:0] bus_i = '0;
    logic [EXT_W-1:0] ext_trig_i = '0;
    logic [ERR_W-1:0] err_i = '0;
    logic [ST_W-1:0]  bstate_i = '0;
    logic [N_BUS_TERMS-1:0][BT_W-1:0] bus_val, bus_care;
    logic [ERR_W-1:0] err_val, err_care;
    logic [N_ST_TERMS-1:0][ST_W-1:0] st_val, st_care;
    logic [LEVELS-1:0][N_TERMS-1:0] lvl_sel;
    logic [LEVELS-1:0] lvl_or, lvl_inv, lvl_trig, lvl_wait;
    logic [LEVELS-1:0][LVL_W-1:0] lvl_next;
    logic [LEVELS-1:0][1:0] lvl_store;
    logic [CNT_W-1:0] cnt_preload;
    logic [POST_W-1:0] post_count;
    logic [LVL_W-1:0] level_o;
    logic trig_o, store_o, done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    trig_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_i(bus_i), .ext_trig_i(ext_trig_i),
        .err_i(err_i), .bstate_i(bstate_i),
        .bus_val_i(bus_val), .bus_care_i(bus_care),
        .err_val_i(err_val), .err_care_i(err_care),
        .st_val_i(st_val), .st_care_i(st_care),
        .lvl_sel_i(lvl_sel), .lvl_or_i(lvl_or), .lvl_inv_i(lvl_inv),
        .lvl_next_i(lvl_next), .lvl_trig_i(lvl_trig), .lvl_wait_i(lvl_wait),
        .lvl_store_i(lvl_store), .cnt_preload_i(cnt_preload),
        .post_count_i(post_count),
        .level_o(level_o), .trig_o(trig_o), .store_o(store_o), .done_o(done_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic clear_cfg();
        bus_val = '0; bus_care = '0; err_val = '0; err_care = '0;
        st_val = '0; st_care = '0; lvl_sel = '0; lvl_or = '0; lvl_inv = '0;
        lvl_next = '0; lvl_trig = '0; lvl_wait = '0; lvl_store = '0;
        cnt_preload = '0; post_count = '0;
        bus_i = '0; ext_trig_i = '0; err_i = '0; bstate_i = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 level in reset", int'(level_o), 0);
        chk("R1 trig in reset", int'(trig_o), 0);
        chk("R1 store in reset", int'(store_o), 0);
        chk("R1 done in reset", int'(done_o), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        clear_cfg();
        do_reset();
        chk("R1 level after release", int'(level_o), 0);
        chk("R1 store after release", int'(store_o), 0);

        // R2: single-term sweep over all eleven terms; level 0 stays put
        for (int i = 0; i < N_TERMS; i++) begin
            int w;
            int msk;
            int v;
            int c;
            w = (i < N_BUS_TERMS) ? BT_W : 8;
            msk = (1 << w) - 1;
            v = (i * 40503 + 12345) & msk;
            c = (i * 7919 + 28561) & msk;
            clear_cfg();
            if (i < N_BUS_TERMS) begin
                bus_val[i] = BT_W'(v); bus_care[i] = BT_W'(c);
            end else if (i == ERR_TERM_IX) begin
                err_val = ERR_W'(v); err_care = ERR_W'(c);
            end else begin
                st_val[i-ST_TERM_IX] = ST_W'(v); st_care[i-ST_TERM_IX] = ST_W'(c);
            end
            lvl_sel[0] = N_TERMS'(1 << i);
            for (int k = 0; k < 12; k++) begin
                int x;
                int sm;
                int exp_hit;
                if (k == 0) x = v;
                else if (k == 1) x = v ^ (~c & msk);
                else x = (k * 2654435 + i * 977) & msk;
                if (k >= 2 && (k % 3 == 0)) x = (v ^ (1 << (k % w))) & msk;
                exp_hit = (((x ^ v) & c) == 0) ? 1 : 0;
                sm = 2 + (k % 2);
                lvl_store[0] = 2'(sm);
                if (i < N_BUS_TERMS) {ext_trig_i, bus_i} = BT_W'(x);
                else if (i == ERR_TERM_IX) err_i = ERR_W'(x);
                else bstate_i = ST_W'(x);
                @(negedge clk);
                chk($sformatf("R2 term %0d vec %0d (R8 select %0d)", i, k, sm),
                    int'(store_o), (sm == 2) ? exp_hit : 1 - exp_hit);
            end
        end

        // R3 R4: combine modes over two bus terms
        clear_cfg();
        bus_val[0] = BT_W'(1); bus_care[0] = BT_W'(1);
        bus_val[1] = BT_W'(2); bus_care[1] = BT_W'(2);
        lvl_store[0] = 2'd2;
        for (int m = 0; m < 2; m++)
            for (int om = 0; om < 2; om++)
                for (int inv = 0; inv < 2; inv++)
                    for (int h = 0; h < 4; h++) begin
                        int a;
                        int b;
                        int e;
                        a = h & 1; b = (h >> 1) & 1;
                        lvl_sel[0] = (m == 1) ? N_TERMS'(3) : '0;
                        lvl_or[0] = om[0]; lvl_inv[0] = inv[0];
                        bus_i = BUS_W'(h);
                        if (m == 1) e = (om == 1) ? (a | b) : (a & b);
                        else e = (om == 1) ? 0 : 1;
                        e = e ^ inv;
                        @(negedge clk);
                        chk($sformatf("%s mask=%0d inv=%0d hits=%0d",
                            (om == 1) ? "R4 or" : "R3 and", m, inv, h),
                            int'(store_o), e);
                    end

        // R5 R6 R7 R8 R9: three-level program
        for (int p = 0; p < 3; p++)
            for (int n = 0; n < 4; n++) begin
                int trues;
                int k;
                bit adv;
                clear_cfg();
                bus_val[0] = BT_W'(1); bus_care[0] = BT_W'(1);
                bus_val[1] = BT_W'(2); bus_care[1] = BT_W'(2);
                lvl_sel[0] = N_TERMS'(1); lvl_wait[0] = 1'b1; lvl_next[0] = 4'd1;
                lvl_store[0] = 2'd1;
                lvl_sel[1] = N_TERMS'(2); lvl_wait[1] = 1'b1; lvl_next[1] = 4'd2;
                lvl_trig[1] = 1'b1; lvl_store[1] = 2'd0;
                lvl_sel[2] = '0; lvl_next[2] = 4'd2; lvl_store[2] = 2'd2;
                cnt_preload = CNT_W'(p);
                post_count = POST_W'(n);
                do_reset();
                for (int j = 0; j <= p; j++) begin
                    bus_i = BUS_W'(1);
                    @(negedge clk);
                    chk($sformatf("R6 level0 wait p=%0d j=%0d", p, j),
                        int'(level_o), (j == p) ? 1 : 0);
                    chk("R8 always-store level", int'(store_o), 1);
                end
                trues = 0; adv = 1'b0; k = 0;
                while (!adv) begin
                    bus_i = (k % 2 == 0) ? BUS_W'(2) : BUS_W'(0);
                    @(negedge clk);
                    if (k % 2 == 0) trues++;
                    adv = (trues == p + 1);
                    chk($sformatf("R6 R5 reload and count p=%0d k=%0d", p, k),
                        int'(level_o), adv ? 2 : 1);
                    chk($sformatf("R7 trigger timing p=%0d k=%0d", p, k),
                        int'(trig_o), adv ? 1 : 0);
                    chk("R8 never-store level", int'(store_o), 0);
                    k++;
                end
                bus_i = '0;
                for (int j = 0; j < n; j++) begin
                    @(negedge clk);
                    chk($sformatf("R9 post store n=%0d j=%0d", n, j), int'(store_o), 1);
                    chk("R9 not done during post", int'(done_o), 0);
                    chk("R7 no second trigger", int'(trig_o), 0);
                end
                @(negedge clk);
                chk($sformatf("R9 done rises n=%0d", n), int'(done_o), 1);
                chk("R9 no store at done", int'(store_o), 0);
                @(negedge clk);
                chk("R9 done held", int'(done_o), 1);
                chk("R9 no store after done", int'(store_o), 0);
                chk("R7 single trigger", int'(trig_o), 0);
            end

        summary();
    end
endmodule